// File: doc/BRIEF.md
# Inter-Processor Mailbox Register Block

This block holds the small register set that two processors use to exchange words and flags. It presents the I/O processor's view of that set. The local processor reaches it through a plain register bus. Reads on that bus are combinational and writes take effect at the clock edge. The bus selects a register by address bits 11 and 7:4 only, so the decode mask is 0x8F0. The remaining address bits alias. Each access is either a full 32-bit word or a 16-bit halfword that touches only bits 15:0.

The other processor drives a valid/ready sideband channel. Through it, that processor deposits its mailbox word, raises bits in the local processor's clear-only flag register, or drops bits in the set-only flag register. `peer_ready` is held high, so the channel never applies back-pressure and every cycle with `peer_valid` high moves one transfer. When a sideband transfer and a bus write hit the same register in the same cycle, the sideband effect wins on every bit it touches.

The registers, by decode value `{addr[11], addr[7:4]}`:
- 0: inbound mailbox, read-only from the bus.
- 1: outbound mailbox.
- 2: flags that the bus can only clear.
- 3: flags that the bus can only set.
- 4: control, with toggle semantics.
- 6: a location that reads as zero.
- Every other value: plain storage.

Top module: `ipc_mbox_regs`

## Requirements
- R1: A sideband transfer with `peer_op`=0 loads `peer_data` into the inbound mailbox. The new value is readable at decode value 0 from the next cycle. Bus writes to decode value 0 leave it unchanged. This holds even when a bus write and a sideband load occur in the same cycle.
- R2: The outbound mailbox (decode value 1) reads back exactly what the bus last wrote.
- R3: A bus write to decode value 2 clears every stored bit whose write-data bit is 1 and leaves the other bits. A sideband transfer with `peer_op`=1 sets the bits given in `peer_data`, and this set wins over a same-cycle bus clear.
- R4: A bus write to decode value 3 sets every stored bit whose write-data bit is 1. A sideband transfer with `peer_op`=2 clears the bits given in `peer_data`, and this clear wins over a same-cycle bus set.
- R5: A control write (decode value 4) with write-data bit 5 or bit 7 set forces control bits 15:12 to 4'b0010. Otherwise bits 15:12 keep their value.
- R6: A control write toggles as a group the bits selected by m = write data bits 7:4. If any selected control bit is 1, all selected bits become 0. Otherwise all selected bits become 1.
- R7: A word read of control returns the register OR 0xF0000002. A halfword read returns its low half OR 0x0002.
- R8: Decode value 6 always reads zero. Writes to it change no readable state.
- R9: Decode values other than 0 to 4 and 6 each select their own plain 32-bit storage word, which reads back what was written.
- R10: Address bits outside mask 0x8F0 are ignored. Addresses differing only in bit 11 select different registers.
- R11: A halfword access (`bus_wide`=0) applies the register's rule to bits 15:0 only. Writes leave bits 31:16 unchanged, and reads return bits 31:16 as zero.
- R12: After reset every register reads zero, except control, which reads only its fixed OR bits.
- R13: `peer_ready` is high in every cycle. A `peer_op` value of 3 is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address within the page |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| peer_valid | input | 1 | Sideband transfer present |
| peer_ready | output | 1 | Sideband accept, always 1 |
| peer_op | input | 2 | 0 load mailbox, 1 raise clear-only flags, 2 drop set-only flags, 3 none |
| peer_data | input | 32 | Sideband word |

## Verification
A corrupted flag or control bit in this block shows up on `bus_rdata` at the very next read of that register. Nothing else masks it, because reads are combinational and there is no pipeline between storage and port. A wrong toggle decision, for example setting where it should clear, shows in the read that follows the write. A missing or extra upper-nibble force also shows on that next read. Halfword errors appear either as a changed upper half on the next word read or as nonzero upper bits on a halfword read. A sideband priority error shows only in the single cycle where both sides hit one register, so the directed tests create that collision deliberately.

// File: rtl/ipc_mbox_pkg.sv
`timescale 1ns/1ps
package ipc_mbox_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int SLOT_W = 5;
  localparam int SLOTS  = 1 << SLOT_W;

  typedef enum logic [2:0] {
    K_INBOX, K_OUTBOX, K_CLRF, K_SETF, K_CTRL, K_ZERO, K_PLAIN
  } reg_kind_e;

  localparam logic [1:0] P_LOAD  = 2'd0;
  localparam logic [1:0] P_RAISE = 2'd1;
  localparam logic [1:0] P_DROP  = 2'd2;

  localparam logic [WORD_W-1:0] CTRL_RD_OR = 32'hF000_0002;

  function automatic reg_kind_e kind_of(input logic [SLOT_W-1:0] slot);
    case (slot)
      5'd0:    return K_INBOX;
      5'd1:    return K_OUTBOX;
      5'd2:    return K_CLRF;
      5'd3:    return K_SETF;
      5'd4:    return K_CTRL;
      5'd6:    return K_ZERO;
      default: return K_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/ipc_mbox_decode.sv
`timescale 1ns/1ps
module ipc_mbox_decode
  import ipc_mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SLOT_W-1:0] slot,
  output reg_kind_e         kind
);
  localparam logic [ADDR_W-1:0] DEC_MASK = ADDR_W'('h8F0);

  logic unused_addr;
  assign unused_addr = ^(addr & ~DEC_MASK);

  assign slot = {addr[11], addr[7:4]};
  assign kind = kind_of(slot);
endmodule

// File: rtl/ipc_mbox_ctrl.sv
`timescale 1ns/1ps
module ipc_mbox_ctrl
  import ipc_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] q
);
  logic [HALF_W-1:0] sel_m;
  logic [HALF_W-1:0] forced;
  logic [HALF_W-1:0] nxt;
  logic              unused_w;

  assign unused_w = ^{wdata[15:8], wdata[3:0]};
  assign sel_m    = {8'h00, wdata[7:4], 4'h0};

  always_comb begin
    forced = q;
    if (wdata[5] || wdata[7]) forced[15:12] = 4'b0010;
    if (|(q & sel_m)) nxt = forced & ~sel_m;
    else              nxt = forced | sel_m;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= nxt;
  end
endmodule

// File: rtl/ipc_mbox_scratch.sv
`timescale 1ns/1ps
module ipc_mbox_scratch
  import ipc_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WORD_W-1:0] lane,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] words [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr_en && slot == SLOT_W'(i)) q <= (q & ~lane) | (wdata & lane);
    end
    assign words[i] = q;
  end

  assign rd_word = words[slot];
endmodule

// File: rtl/ipc_mbox_regs.sv
`timescale 1ns/1ps
module ipc_mbox_regs
  import ipc_mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_wide,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              peer_valid,
  output logic              peer_ready,
  input  logic [1:0]        peer_op,
  input  logic [31:0]       peer_data
);
  logic [SLOT_W-1:0] dec_slot;
  reg_kind_e         dec_kind;
  logic [WORD_W-1:0] lane, wmask;
  logic [WORD_W-1:0] inbox_q, outbox_q, clrf_q, setf_q;
  logic [WORD_W-1:0] clrf_nxt, setf_nxt;
  logic [HALF_W-1:0] ctrl_q;
  logic [WORD_W-1:0] plain_rd, raw_rd;
  logic              peer_fire;

  ipc_mbox_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .slot(dec_slot), .kind(dec_kind)
  );

  assign peer_ready = 1'b1;
  assign peer_fire  = peer_valid && peer_ready;
  assign lane       = bus_wide ? '1 : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign wmask      = bus_wdata & lane;

  always_comb begin
    clrf_nxt = clrf_q;
    if (bus_wr && dec_kind == K_CLRF)     clrf_nxt = clrf_nxt & ~wmask;
    if (peer_fire && peer_op == P_RAISE)  clrf_nxt = clrf_nxt | peer_data;
    setf_nxt = setf_q;
    if (bus_wr && dec_kind == K_SETF)     setf_nxt = setf_nxt | wmask;
    if (peer_fire && peer_op == P_DROP)   setf_nxt = setf_nxt & ~peer_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inbox_q  <= '0;
      outbox_q <= '0;
      clrf_q   <= '0;
      setf_q   <= '0;
    end else begin
      if (peer_fire && peer_op == P_LOAD) inbox_q <= peer_data;
      if (bus_wr && dec_kind == K_OUTBOX)  outbox_q <= (outbox_q & ~lane) | wmask;
      clrf_q <= clrf_nxt;
      setf_q <= setf_nxt;
    end
  end

  ipc_mbox_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr && dec_kind == K_CTRL),
    .wdata(bus_wdata[HALF_W-1:0]),
    .q(ctrl_q)
  );

  ipc_mbox_scratch u_plain (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr && dec_kind == K_PLAIN),
    .slot(dec_slot), .lane(lane), .wdata(bus_wdata),
    .rd_word(plain_rd)
  );

  always_comb begin
    case (dec_kind)
      K_INBOX:  raw_rd = inbox_q;
      K_OUTBOX: raw_rd = outbox_q;
      K_CLRF:   raw_rd = clrf_q;
      K_SETF:   raw_rd = setf_q;
      K_CTRL:   raw_rd = {{HALF_W{1'b0}}, ctrl_q} | CTRL_RD_OR;
      K_ZERO:   raw_rd = '0;
      default:  raw_rd = plain_rd;
    endcase
    bus_rdata = raw_rd & lane;
  end
endmodule

// File: rtl/ipc_mbox_sva.sv
`timescale 1ns/1ps
module ipc_mbox_sva
  import ipc_mbox_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_wide,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        peer_valid,
  input logic [1:0]  peer_op,
  input logic [31:0] peer_data,
  input reg_kind_e   dec_kind,
  input logic [31:0] inbox_q,
  input logic [31:0] clrf_q,
  input logic [31:0] setf_q,
  input logic [15:0] ctrl_q
);
  p_inbox_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_valid && peer_op == P_LOAD) |=> inbox_q == $past(peer_data));

  p_inbox_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(peer_valid && peer_op == P_LOAD) |=> $stable(inbox_q));

  p_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dec_kind == K_CLRF && !(peer_valid && peer_op == P_RAISE))
    |=> (clrf_q[15:0] & $past(bus_wdata[15:0])) == 16'h0);

  p_set_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dec_kind == K_SETF && !(peer_valid && peer_op == P_DROP))
    |=> (setf_q[15:0] & $past(bus_wdata[15:0])) == $past(bus_wdata[15:0]));

  p_ctrl_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dec_kind == K_CTRL && (bus_wdata[5] || bus_wdata[7]))
    |=> ctrl_q[15:12] == 4'b0010);

  p_ctrl_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_kind == K_CTRL |-> bus_rdata[1] && (!bus_wide || bus_rdata[31:28] == 4'hF));

  p_zero_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_kind == K_ZERO |-> bus_rdata == 32'h0);

  p_half_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wide && dec_kind == K_CLRF && !peer_valid)
    |=> clrf_q[31:16] == $past(clrf_q[31:16]));
endmodule

bind ipc_mbox_regs ipc_mbox_sva u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wide(bus_wide),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .peer_valid(peer_valid),
  .peer_op(peer_op), .peer_data(peer_data), .dec_kind(dec_kind),
  .inbox_q(inbox_q), .clrf_q(clrf_q), .setf_q(setf_q), .ctrl_q(ctrl_q)
);

// File: tb/tb_ipc_mbox_regs.sv
`timescale 1ns/1ps
module tb_ipc_mbox_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_wide = 1'b1;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        peer_valid = 1'b0;
  logic        peer_ready;
  logic [1:0]  peer_op = 2'd3;
  logic [31:0] peer_data = '0;
  int          n_vec = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  ipc_mbox_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .peer_valid(peer_valid), .peer_ready(peer_ready), .peer_op(peer_op),
    .peer_data(peer_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic w, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_wide = w; bus_wr = 1'b0;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  // one cycle with an optional bus write and an optional sideband transfer
  task automatic cyc(input logic bw, input logic [11:0] a, input logic w, input logic [31:0] d,
                     input logic pv, input logic [1:0] op, input logic [31:0] pd);
    @(negedge clk);
    bus_wr = bw; bus_addr = a; bus_wide = w; bus_wdata = d;
    peer_valid = pv; peer_op = op; peer_data = pd;
    @(negedge clk);
    bus_wr = 1'b0; peer_valid = 1'b0; peer_op = 2'd3;
  endtask

  task automatic t_reset;
    rd(12'h000, 1, 32'h0, "R12 inbox");
    rd(12'h010, 1, 32'h0, "R12 outbox");
    rd(12'h020, 1, 32'h0, "R12 clrf");
    rd(12'h030, 1, 32'h0, "R12 setf");
    rd(12'h040, 1, 32'hF000_0002, "R12 ctrl");
    rd(12'h050, 1, 32'h0, "R12 plain");
    check("R13 ready", {31'h0, peer_ready}, 32'h1);
  endtask

  task automatic t_inbox;
    cyc(0, 12'h000, 1, 0, 1, 2'd0, 32'hCAFE_F00D);
    rd(12'h000, 1, 32'hCAFE_F00D, "R1 load");
    rd(12'h000, 0, 32'h0000_F00D, "R11 inbox half");
    cyc(1, 12'h000, 1, 32'h1234_5678, 0, 2'd3, 0);
    rd(12'h000, 1, 32'hCAFE_F00D, "R1 bus write ignored");
    cyc(1, 12'h000, 1, 32'h1234_5678, 1, 2'd0, 32'h0000_A5A5);
    rd(12'h000, 1, 32'h0000_A5A5, "R1 collision");
    cyc(0, 12'h000, 1, 0, 1, 2'd3, 32'hFFFF_FFFF);
    rd(12'h000, 1, 32'h0000_A5A5, "R13 op3 no effect");
  endtask

  task automatic t_outbox;
    cyc(1, 12'h010, 1, 32'h1122_3344, 0, 2'd3, 0);
    rd(12'h010, 1, 32'h1122_3344, "R2 word");
    cyc(1, 12'h010, 0, 32'hAAAA_5566, 0, 2'd3, 0);
    rd(12'h010, 1, 32'h1122_5566, "R11 outbox half write");
    rd(12'h31C, 1, 32'h1122_5566, "R10 alias");
    rd(12'h810, 1, 32'h0, "R10 bit11 distinct");
  endtask

  task automatic t_clrf;
    cyc(0, 12'h020, 1, 0, 1, 2'd1, 32'hFF00_00F0);
    rd(12'h020, 1, 32'hFF00_00F0, "R3 peer raise");
    cyc(1, 12'h020, 1, 32'h0F00_0030, 0, 2'd3, 0);
    rd(12'h020, 1, 32'hF000_00C0, "R3 bus clear");
    cyc(1, 12'h020, 0, 32'hFFFF_00C0, 0, 2'd3, 0);
    rd(12'h020, 1, 32'hF000_0000, "R11 clrf half");
    cyc(1, 12'h020, 1, 32'h0000_0001, 1, 2'd1, 32'h0000_0001);
    rd(12'h020, 1, 32'hF000_0001, "R3 peer wins");
  endtask

  task automatic t_setf;
    cyc(1, 12'h030, 1, 32'h0000_0005, 0, 2'd3, 0);
    rd(12'h030, 1, 32'h0000_0005, "R4 bus set");
    cyc(1, 12'h030, 0, 32'h1234_0010, 0, 2'd3, 0);
    rd(12'h030, 1, 32'h0000_0015, "R11 setf half");
    cyc(0, 12'h030, 1, 0, 1, 2'd2, 32'h0000_0004);
    rd(12'h030, 1, 32'h0000_0011, "R4 peer drop");
    cyc(1, 12'h030, 1, 32'h0000_0002, 1, 2'd2, 32'h0000_0002);
    rd(12'h030, 1, 32'h0000_0011, "R4 peer wins");
  endtask

  task automatic t_ctrl;
    cyc(1, 12'h040, 1, 32'h0000_0020, 0, 2'd3, 0);
    rd(12'h040, 1, 32'hF000_2022, "R5 force and R6 set");
    cyc(1, 12'h040, 1, 32'h0000_0010, 0, 2'd3, 0);
    rd(12'h040, 1, 32'hF000_2032, "R6 set bit4");
    cyc(1, 12'h040, 1, 32'h0000_0030, 0, 2'd3, 0);
    rd(12'h040, 1, 32'hF000_2002, "R6 clear group");
    cyc(1, 12'h040, 1, 32'h0000_0050, 0, 2'd3, 0);
    rd(12'h040, 1, 32'hF000_2052, "R6 set group");
    cyc(1, 12'h040, 1, 32'h0000_0060, 0, 2'd3, 0);
    rd(12'h040, 1, 32'hF000_2012, "R6 partial hit clears");
    cyc(1, 12'h040, 1, 32'h0000_F010, 0, 2'd3, 0);
    rd(12'h040, 1, 32'hF000_2002, "R5 no force");
    rd(12'h040, 0, 32'h0000_2002, "R7 half read");
  endtask

  task automatic t_plain;
    cyc(1, 12'h050, 1, 32'hDEAD_BEEF, 0, 2'd3, 0);
    rd(12'h050, 1, 32'hDEAD_BEEF, "R9 plain word");
    rd(12'h850, 1, 32'h0, "R10 bit11 plain");
    cyc(1, 12'h060, 1, 32'hFFFF_FFFF, 0, 2'd3, 0);
    rd(12'h060, 1, 32'h0, "R8 zero read");
    rd(12'h050, 1, 32'hDEAD_BEEF, "R8 write no effect");
    cyc(1, 12'h8F4, 0, 32'h7777_1234, 0, 2'd3, 0);
    rd(12'h8F0, 1, 32'h0000_1234, "R11 plain half");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_inbox;
    t_outbox;
    t_clrf;
    t_setf;
    t_ctrl;
    t_plain;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule